// File: doc/BRIEF.md
# Multi-Bit ECC Correction Sequencer

This block runs the correction phase that follows a 4-bit-strength ECC decode of a 512-byte sector. On a `start` pulse it reads the four syndrome words from an external engine. If all four are zero, it reports a clean sector at once. Otherwise it does the following:

- It clears any stale location result with a dummy read.
- It pulses the location-start control and waits out the engine's unreliable start-up window.
- It polls the engine state until that state is final.
- It fetches up to four packed error address/value pairs, turns each address into a sector byte index, and sends XOR corrections to a sector buffer port.

Register reads go through a request/acknowledge port that carries a register select code. Each buffer correction is a single request/acknowledge transfer; the buffer performs the read-modify-write. The result is a count of the corrections actually applied, or an uncorrectable flag. The result is presented together with a one-cycle `done` pulse.

Top module: `ecc_fix_seq`

## Requirements
- R1: When the four syndrome reads (select codes 0, 1, 2, 3, in that order) all return zero, `done` follows with `corr_count`=0 and `uncorrectable`=0. There is no `calc_go` pulse and no further register read.
- R2: When any syndrome word is nonzero, the block reads select 5 (first address pair) as a dummy read. `calc_go` then pulses for exactly one cycle, in the cycle after that read completes.
- R3: After `calc_go`, each status read (select 4) whose state field, bits 11:8, is below 4 is not treated as a result. The status is read again until a read returns a state of 4 or more, or until CLK_MHZ*TIMEOUT_US cycles have passed. Either event starts the result polling.
- R4: A polled state of 0 causes one dummy read of select 7 (first value pair), then `done` with `corr_count`=0 and `uncorrectable`=0.
- R5: A polled state of 1 causes one dummy read of select 7, then `done` with `uncorrectable`=1 and `corr_count`=0.
- R6: While polling, a state of 4 or more causes another status read.
- R7: A polled state of 2 or 3 sets the error count to 1 plus status bits 17:16. Errors 0 and 1 read select 5 and then select 7; errors 2 and 3 read select 6 and then select 8. Odd-numbered errors take bits 31:16 of each word and even-numbered errors take bits 15:0. At most four errors are processed.
- R8: The address is the low 10 bits of its half-word, and the byte index is 519 minus that address. A buffer write with `buf_idx` = index and `buf_xor` = low 8 bits of the value half-word is issued only when 0 <= index < 512. Other addresses are skipped.
- R9: `done` is a one-cycle pulse. `corr_count` equals the number of buffer writes issued in the run. `corr_count` and `uncorrectable` change only in a `done` cycle and are 0 after reset.
- R10: A `start` pulse that arrives while a run is in progress is ignored.
- R11: Once raised, `rd_req` is held with a stable `rd_sel` until `rd_ack`, and `buf_req` is held with a stable `buf_idx` and `buf_xor` until `buf_ack`. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a correction run (single-cycle pulse) |
| done | output | 1 | Run finished; result valid in this cycle |
| corr_count | output | 3 | Number of corrections applied in the last run |
| uncorrectable | output | 1 | Last run found five or more errors |
| calc_go | output | 1 | One-cycle pulse that starts error-location calculation |
| rd_req | output | 1 | Register read request |
| rd_sel | output | 4 | Register select: 0-3 syndrome, 4 status, 5/6 address pairs, 7/8 value pairs |
| rd_ack | input | 1 | Read complete; rd_data valid in this cycle |
| rd_data | input | 32 | Read data |
| buf_req | output | 1 | Sector byte correction request |
| buf_idx | output | 9 | Byte index in the sector |
| buf_xor | output | 8 | Mask XORed into the byte |
| buf_ack | input | 1 | Correction applied |

## Verification
Every read completes on the edge where `rd_ack` is seen high. The next request or `calc_go` appears in the following cycle. `done` comes one cycle after the last read or buffer acknowledge, and the result outputs change in that same `done` cycle. The bench drives acknowledges and samples every output on the falling clock edge. It compares each completed read select and each buffer write, in order, against a queue that a behavioural model builds from the scenario's register contents. The guard window is checked by counting cycles from `calc_go` to the first address fetch: that count must be short when the engine reports busy, and must reach the full timeout when the engine never does.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  // register select codes on the read port
  typedef enum logic [3:0] {
    SEL_SYN0   = 4'd0,
    SEL_SYN1   = 4'd1,
    SEL_SYN2   = 4'd2,
    SEL_SYN3   = 4'd3,
    SEL_STATUS = 4'd4,
    SEL_LOC_P0 = 4'd5,
    SEL_LOC_P1 = 4'd6,
    SEL_MAG_P0 = 4'd7,
    SEL_MAG_P1 = 4'd8
  } reg_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SYN,
    ST_CLR,
    ST_GO,
    ST_GUARD,
    ST_POLL,
    ST_DRAIN,
    ST_LOC,
    ST_MAG,
    ST_FIX,
    ST_DONE
  } seq_state_e;

  // engine status word layout
  localparam int ENG_STATE_LSB = 8;
  localparam int ENG_STATE_W   = 4;
  localparam int ENG_CNT_LSB   = 16;
  localparam int ENG_CNT_W     = 2;
  localparam int ENG_BUSY_MIN  = 4;

endpackage

// File: rtl/ecc_fix_rst_sync.sv
module ecc_fix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/ecc_fix_guard_timer.sv
module ecc_fix_guard_timer #(
  parameter int LIMIT = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LIM);
  assign cnt_en  = clr | (en & ~expired);

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ecc_fix_locate.sv
module ecc_fix_locate #(
  parameter int ADDR_W       = 10,
  parameter int MAG_W        = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int PARITY_PAD   = 7
) (
  input  logic [ADDR_W-1:0]               lo_bits,
  input  logic [ADDR_W-1:0]               hi_bits,
  input  logic                            upper,
  input  logic [ADDR_W-1:0]               addr_in,
  output logic [ADDR_W-1:0]               addr_half,
  output logic [MAG_W-1:0]                mag_half,
  output logic [$clog2(SECTOR_BYTES)-1:0] idx,
  output logic                            hit
);

  localparam int IDX_W  = $clog2(SECTOR_BYTES);
  localparam int DIFF_W = ADDR_W + 2;
  localparam logic [DIFF_W-1:0] BASE = DIFF_W'(SECTOR_BYTES + PARITY_PAD);
  localparam logic [DIFF_W-1:0] SPAN = DIFF_W'(SECTOR_BYTES);

  logic [DIFF_W-1:0] diff;

  assign addr_half = upper ? hi_bits : lo_bits;
  assign mag_half  = addr_half[MAG_W-1:0];

  // byte index counted back from the end of sector plus parity pad
  assign diff = BASE - {2'b00, addr_in};
  assign hit  = ~diff[DIFF_W-1] & (diff < SPAN);
  assign idx  = diff[IDX_W-1:0];

endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_fix_pkg::*;
#(
  parameter int CLK_MHZ      = 125,
  parameter int TIMEOUT_US   = 100,
  parameter int SECTOR_BYTES = 512,
  parameter int PARITY_PAD   = 7,
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  output logic                            done,
  output logic [2:0]                      corr_count,
  output logic                            uncorrectable,
  output logic                            calc_go,
  output logic                            rd_req,
  output logic [3:0]                      rd_sel,
  input  logic                            rd_ack,
  input  logic [DATA_W-1:0]               rd_data,
  output logic                            buf_req,
  output logic [$clog2(SECTOR_BYTES)-1:0] buf_idx,
  output logic [7:0]                      buf_xor,
  input  logic                            buf_ack
);

  localparam int TMO_CYC = CLK_MHZ * TIMEOUT_US;
  localparam int IDX_W   = $clog2(SECTOR_BYTES);
  localparam int HALF_W  = DATA_W / 2;
  localparam int MAG_W   = 8;
  localparam int CNT_W   = 3;

  logic srst_n;

  seq_state_e       st_q, st_d;
  logic [1:0]       syn_idx_q, syn_idx_d;
  logic             syn_nz_q, syn_nz_d;
  logic [1:0]       k_q, k_d;
  logic [1:0]       klast_q, klast_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [MAG_W-1:0] mag_q, mag_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             unc_q, unc_d;
  logic [CNT_W-1:0] res_cnt_q;
  logic             res_unc_q;
  logic             res_load;

  logic             rd_xfer;
  logic [ENG_STATE_W-1:0] eng_state;
  logic [ENG_CNT_W-1:0]   eng_cnt;
  logic             tmo_expired;
  logic [ADDR_W-1:0] loc_half;
  logic [MAG_W-1:0] mag_half;
  logic [IDX_W-1:0] loc_idx;
  logic             loc_hit;

  ecc_fix_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ecc_fix_guard_timer #(.LIMIT(TMO_CYC)) u_guard (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (st_q == ST_GO),
    .en      (st_q == ST_GUARD),
    .expired (tmo_expired)
  );

  ecc_fix_locate #(
    .ADDR_W       (ADDR_W),
    .MAG_W        (MAG_W),
    .SECTOR_BYTES (SECTOR_BYTES),
    .PARITY_PAD   (PARITY_PAD)
  ) u_loc (
    .lo_bits   (rd_data[0 +: ADDR_W]),
    .hi_bits   (rd_data[HALF_W +: ADDR_W]),
    .upper     (k_q[0]),
    .addr_in   (addr_q),
    .addr_half (loc_half),
    .mag_half  (mag_half),
    .idx       (loc_idx),
    .hit       (loc_hit)
  );

  assign rd_xfer   = rd_req & rd_ack;
  assign eng_state = rd_data[ENG_STATE_LSB +: ENG_STATE_W];
  assign eng_cnt   = rd_data[ENG_CNT_LSB +: ENG_CNT_W];

  // next-state process
  always_comb begin
    st_d      = st_q;
    syn_idx_d = syn_idx_q;
    syn_nz_d  = syn_nz_q;
    k_d       = k_q;
    klast_d   = klast_q;
    addr_d    = addr_q;
    mag_d     = mag_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    unc_d     = unc_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d      = ST_SYN;
          syn_idx_d = 2'd0;
          syn_nz_d  = 1'b0;
          cnt_d     = '0;
          unc_d     = 1'b0;
        end
      end
      ST_SYN: begin
        if (rd_xfer) begin
          syn_nz_d = syn_nz_q | (|rd_data);
          if (syn_idx_q == 2'd3) st_d = syn_nz_d ? ST_CLR : ST_DONE;
          else                   syn_idx_d = syn_idx_q + 2'd1;
        end
      end
      ST_CLR:   if (rd_xfer) st_d = ST_GO;
      ST_GO:    st_d = ST_GUARD;
      ST_GUARD: begin
        if (rd_xfer && ((eng_state >= ENG_STATE_W'(ENG_BUSY_MIN)) || tmo_expired))
          st_d = ST_POLL;
      end
      ST_POLL: begin
        if (rd_xfer) begin
          case (eng_state)
            4'd0: st_d = ST_DRAIN;
            4'd1: begin st_d = ST_DRAIN; unc_d = 1'b1; end
            4'd2, 4'd3: begin
              st_d    = ST_LOC;
              k_d     = 2'd0;
              klast_d = eng_cnt;
            end
            default: st_d = ST_POLL;
          endcase
        end
      end
      ST_DRAIN: if (rd_xfer) st_d = ST_DONE;
      ST_LOC: begin
        if (rd_xfer) begin
          addr_d = loc_half;
          st_d   = ST_MAG;
        end
      end
      ST_MAG: begin
        if (rd_xfer) begin
          mag_d = mag_half;
          if (loc_hit) begin
            idx_d = loc_idx;
            st_d  = ST_FIX;
          end else if (k_q == klast_q) begin
            st_d = ST_DONE;
          end else begin
            k_d  = k_q + 2'd1;
            st_d = ST_LOC;
          end
        end
      end
      ST_FIX: begin
        if (buf_ack) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (k_q == klast_q) begin
            st_d = ST_DONE;
          end else begin
            k_d  = k_q + 2'd1;
            st_d = ST_LOC;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign res_load = (st_d == ST_DONE) && (st_q != ST_DONE);

  // register process
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q      <= ST_IDLE;
      syn_idx_q <= '0;
      syn_nz_q  <= 1'b0;
      k_q       <= '0;
      klast_q   <= '0;
      addr_q    <= '0;
      mag_q     <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      unc_q     <= 1'b0;
      res_cnt_q <= '0;
      res_unc_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      syn_idx_q <= syn_idx_d;
      syn_nz_q  <= syn_nz_d;
      k_q       <= k_d;
      klast_q   <= klast_d;
      addr_q    <= addr_d;
      mag_q     <= mag_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      unc_q     <= unc_d;
      if (res_load) begin
        res_cnt_q <= cnt_d;
        res_unc_q <= unc_d;
      end
    end
  end

  // outputs decoded from registered state
  always_comb begin
    rd_req = 1'b1;
    rd_sel = SEL_SYN0;
    case (st_q)
      ST_SYN:   rd_sel = 4'(syn_idx_q);
      ST_CLR:   rd_sel = SEL_LOC_P0;
      ST_GUARD,
      ST_POLL:  rd_sel = SEL_STATUS;
      ST_DRAIN: rd_sel = SEL_MAG_P0;
      ST_LOC:   rd_sel = k_q[1] ? SEL_LOC_P1 : SEL_LOC_P0;
      ST_MAG:   rd_sel = k_q[1] ? SEL_MAG_P1 : SEL_MAG_P0;
      default:  rd_req = 1'b0;
    endcase
  end

  assign calc_go       = (st_q == ST_GO);
  assign done          = (st_q == ST_DONE);
  assign buf_req       = (st_q == ST_FIX);
  assign buf_idx       = idx_q;
  assign buf_xor       = mag_q;
  assign corr_count    = res_cnt_q;
  assign uncorrectable = res_unc_q;

endmodule

// File: rtl/ecc_fix_seq_chk.sv
module ecc_fix_seq_chk
  import ecc_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            done,
  input logic [2:0]                      corr_count,
  input logic                            uncorrectable,
  input logic                            calc_go,
  input logic                            rd_req,
  input logic [3:0]                      rd_sel,
  input logic                            rd_ack,
  input logic                            buf_req,
  input logic [$clog2(SECTOR_BYTES)-1:0] buf_idx,
  input logic [7:0]                      buf_xor,
  input logic                            buf_ack
);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_sel));

  p_buf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_req && !buf_ack |=> buf_req && $stable(buf_idx) && $stable(buf_xor));

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && buf_req));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(corr_count) && $stable(uncorrectable));

  p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    calc_go |=> !calc_go);

  p_go_after_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    calc_go |-> $past(rd_req && rd_ack && (rd_sel == 4'(SEL_LOC_P0))));

  p_unc_nofix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && uncorrectable |-> corr_count == 3'd0);

  p_count_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> corr_count <= 3'd4);

endmodule

bind ecc_fix_seq ecc_fix_seq_chk #(.SECTOR_BYTES(SECTOR_BYTES)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .done          (done),
  .corr_count    (corr_count),
  .uncorrectable (uncorrectable),
  .calc_go       (calc_go),
  .rd_req        (rd_req),
  .rd_sel        (rd_sel),
  .rd_ack        (rd_ack),
  .buf_req       (buf_req),
  .buf_idx       (buf_idx),
  .buf_xor       (buf_xor),
  .buf_ack       (buf_ack)
);

// File: tb/test_ecc_fix_seq.sv
`timescale 1ns/1ps
module test_ecc_fix_seq;

  localparam int TMO = 125 * 100;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        done;
  logic [2:0]  corr_count;
  logic        uncorrectable;
  logic        calc_go;
  logic        rd_req;
  logic [3:0]  rd_sel;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        buf_req;
  logic [8:0]  buf_idx;
  logic [7:0]  buf_xor;
  logic        buf_ack;

  ecc_fix_seq i_ecc_fix_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .corr_count(corr_count), .uncorrectable(uncorrectable), .calc_go(calc_go),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_data(rd_data),
    .buf_req(buf_req), .buf_idx(buf_idx), .buf_xor(buf_xor), .buf_ack(buf_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // scenario contents
  logic [31:0] syn [4];
  logic [31:0] st_scr [8];
  int          st_len;
  int          st_pos;
  logic [31:0] loc_a, loc_b, mag_a, mag_b;
  bit          tmo_mode;
  string       tag;

  // expectations
  int exp_rd [$];
  int exp_wr [$];
  int exp_cnt, exp_unc, exp_go;

  // observation
  int cyc = 0;
  int go_count, go_cyc, first_loc, done_seen;
  int rw = 0, bw = 0, rd_first_sel = 0;

  task automatic chk(input bit ok, input string t, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  function automatic int fld_state(input logic [31:0] w);
    return int'((w >> 8) & 32'hf);
  endfunction

  // behavioural model of the expected read and write sequence
  task automatic build_exp();
    int p;
    int s;
    logic [31:0] w;
    int n;
    exp_rd.delete();
    exp_wr.delete();
    exp_cnt = 0;
    exp_unc = 0;
    for (int i = 0; i < 4; i++) exp_rd.push_back(i);
    if ((syn[0] | syn[1] | syn[2] | syn[3]) == 0) begin
      exp_go = 0;
      return;
    end
    exp_go = 1;
    exp_rd.push_back(5);
    p = 0;
    w = st_scr[0];
    if (tmo_mode) begin
      exp_rd.push_back(4);
      w = st_scr[0];
    end else begin
      do begin
        exp_rd.push_back(4);
        w = st_scr[p];
        if (p < st_len - 1) p++;
      end while (fld_state(w) < 4);
      do begin
        exp_rd.push_back(4);
        w = st_scr[p];
        if (p < st_len - 1) p++;
      end while (fld_state(w) >= 4);
    end
    s = fld_state(w);
    if (s <= 1) begin
      exp_rd.push_back(7);
      exp_unc = (s == 1);
      return;
    end
    n = 1 + int'((w >> 16) & 32'h3);
    for (int k = 0; k < n; k++) begin
      logic [31:0] aw, vw;
      int a, v, ix;
      aw = (k < 2) ? loc_a : loc_b;
      vw = (k < 2) ? mag_a : mag_b;
      exp_rd.push_back((k < 2) ? 5 : 6);
      exp_rd.push_back((k < 2) ? 7 : 8);
      a  = int'(((k & 1) ? (aw >> 16) : aw) & 32'h3ff);
      v  = int'(((k & 1) ? (vw >> 16) : vw) & 32'hff);
      ix = 519 - a;
      if (ix >= 0 && ix < 512) begin
        exp_wr.push_back((ix << 8) | v);
        exp_cnt++;
      end
    end
  endtask

  task automatic serve_read();
    int sel;
    int want;
    sel = int'(rd_sel);
    chk(sel == rd_first_sel, "R11 select held until ack", sel, rd_first_sel);
    if (tmo_mode && exp_rd.size() > 0 && exp_rd[0] == 4 && sel == 4) begin
      want = 4;
    end else begin
      if (tmo_mode && exp_rd.size() > 0 && exp_rd[0] == 4 && go_count > 0) void'(exp_rd.pop_front());
      if (exp_rd.size() == 0) begin
        chk(0, {tag, " unexpected read"}, sel, -1);
        want = sel;
      end else begin
        want = exp_rd.pop_front();
        chk(sel == want, {tag, " read select order"}, sel, want);
      end
    end
    case (sel)
      0, 1, 2, 3: rd_data = syn[sel];
      4: begin
        rd_data = st_scr[st_pos];
        if (st_pos < st_len - 1) st_pos++;
      end
      5: rd_data = loc_a;
      6: rd_data = loc_b;
      7: rd_data = mag_a;
      8: rd_data = mag_b;
      default: rd_data = 32'h0;
    endcase
    if (sel == 5 && go_count > 0 && first_loc < 0) first_loc = cyc;
  endtask

  task automatic serve_buf();
    int act;
    int want;
    act = (int'(buf_idx) << 8) | int'(buf_xor);
    if (exp_wr.size() == 0) begin
      chk(0, "R8 unexpected buffer write", act, -1);
    end else begin
      want = exp_wr.pop_front();
      chk(act == want, "R8 buffer index/mask", act, want);
    end
  endtask

  // responder and per-cycle comparison, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_ack) begin
        rd_ack = 1'b0;
        rw = 0;
      end else if (rd_req) begin
        rw++;
        if (rw == 1) rd_first_sel = int'(rd_sel);
        if (rw == 2) begin
          serve_read();
          rd_ack = 1'b1;
        end
      end else begin
        rw = 0;
      end
      if (buf_ack) begin
        buf_ack = 1'b0;
        bw = 0;
      end else if (buf_req) begin
        bw++;
        if (bw == 2) begin
          serve_buf();
          buf_ack = 1'b1;
        end
      end else begin
        bw = 0;
      end
      if (calc_go) begin
        go_count++;
        go_cyc = cyc;
      end
      if (done) begin
        done_seen++;
        chk(int'(corr_count) == exp_cnt, {tag, " R9 corrected count"}, int'(corr_count), exp_cnt);
        chk(int'(uncorrectable) == exp_unc, {tag, " R5 uncorrectable flag"}, int'(uncorrectable), exp_unc);
        chk(exp_rd.size() == 0, {tag, " R7 reads outstanding at done"}, exp_rd.size(), 0);
        chk(exp_wr.size() == 0, {tag, " R8 writes outstanding at done"}, exp_wr.size(), 0);
      end
    end
  end

  task automatic run(input string t);
    int w;
    tag = t;
    build_exp();
    go_count = 0;
    go_cyc = -1;
    first_loc = -1;
    done_seen = 0;
    st_pos = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (done_seen == 0 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(done_seen != 0, {t, " R9 watchdog: done never came"}, w, 0);
    repeat (6) @(negedge clk);
    chk(go_count == exp_go, {t, " R2 calc_go pulses"}, go_count, exp_go);
    chk(done_seen == 1, {t, " R9 done pulses"}, done_seen, 1);
  endtask

  task automatic clear_scn();
    for (int i = 0; i < 4; i++) syn[i] = 32'h0;
    for (int i = 0; i < 8; i++) st_scr[i] = 32'h0;
    st_len = 1;
    loc_a = 0; loc_b = 0; mag_a = 0; mag_b = 0;
    tmo_mode = 0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_ack = 1'b0; buf_ack = 1'b0; rd_data = 32'h0;
    clear_scn();
    tag = "reset";
    repeat (3) @(negedge clk);
    chk(done == 0 && rd_req == 0 && buf_req == 0 && calc_go == 0, "R9 reset outputs idle",
        int'({done, rd_req, buf_req, calc_go}), 0);
    chk(corr_count == 0 && uncorrectable == 0, "R9 reset result", int'({uncorrectable, corr_count}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: clean sector
    clear_scn();
    run("R1 zero syndrome");

    // R3 + R7 + R8: false complete, busy, then four errors
    clear_scn();
    syn[2] = 32'h0000_0040;
    st_scr[0] = 32'h0000_0300; st_scr[1] = 32'h0000_0300;
    st_scr[2] = 32'h0000_0900; st_scr[3] = 32'h0000_0900;
    st_scr[4] = 32'h0003_0200; st_len = 5;
    loc_a = {16'h0008, 16'hFE07};     // even: 519 -> idx 0 ; odd: 8 -> idx 511
    loc_b = {16'h0064, 16'h0005};     // even: 5 dropped ; odd: 100 -> idx 419
    mag_a = {16'h0080, 16'h1201};
    mag_b = {16'hAB40, 16'h0033};
    run("R7 four errors");
    chk(first_loc - go_cyc < 60, "R3 guard leaves on busy state", first_loc - go_cyc, 60);
    repeat (20) @(negedge clk);
    chk(int'(corr_count) == 3, "R9 result held after done", int'(corr_count), 3);

    // R4: state 0 after busy
    clear_scn();
    syn[0] = 32'h8000_0000;
    st_scr[0] = 32'h0000_0800; st_scr[1] = 32'h0000_0000; st_len = 2;
    run("R4 no error state");

    // R5: five or more errors
    clear_scn();
    syn[3] = 32'h1;
    st_scr[0] = 32'h0000_0500; st_scr[1] = 32'h0000_0100; st_len = 2;
    run("R5 uncorrectable");

    // R6 + R8 + R10: poll through busy, one dropped address, stray start
    clear_scn();
    syn[1] = 32'h0000_1000;
    st_scr[0] = 32'h0000_0C00; st_scr[1] = 32'h0000_0F00;
    st_scr[2] = 32'h0001_0300; st_len = 3;
    loc_a = {16'h012C, 16'h0000};     // even: 0 -> 519 dropped ; odd: 300 -> idx 219
    mag_a = {16'h005A, 16'h00FF};
    fork
      run("R6 busy poll");
      begin
        repeat (12) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(done_seen == 1, "R10 start during run ignored", done_seen, 1);

    // R3: engine never leaves the false complete state, timeout path
    clear_scn();
    syn[0] = 32'h2;
    st_scr[0] = 32'h0000_0300; st_len = 1;
    loc_a = {16'h0000, 16'h0207};     // 519 -> idx 0
    mag_a = {16'h0000, 16'h00FF};
    tmo_mode = 1;
    run("R3 guard timeout");
    chk(first_loc - go_cyc >= TMO, "R3 guard waits full timeout", first_loc - go_cyc, TMO);
    chk(first_loc - go_cyc <= TMO + 30, "R3 guard ends after timeout", first_loc - go_cyc, TMO + 30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL R9 global watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule